// File: doc/BRIEF.md
# SDRAM Row-Hit Burst Access Controller

This block sits between a CPU-style single-word bus and a synchronous DRAM. It sequences each bus request into SDRAM commands. It keeps track of the row it last activated, so a request that lands in that same row can be served by a bare column command, without closing and reopening the row. A request that lands in a different row closes the open row, opens the new one and then issues the column command. When burst mode is off, every access opens its row, issues the column command and closes the row again.

A 3-bit multiplex setting fixes how many low address bits form the column. The bits above them form the row, and the row-hit compare uses that row. The CAS latency can be 1, 2 or 3. Read DQM acts two cycles after it is driven. Because of this, the controller masks nothing on a read except by timing DQM low two cycles ahead of the data. At latency 1 that slot falls before the READ command, so burst mode is forced off at latency 1. Bus address bit 15 selects SDRAM space when it is 0. Requests with bit 15 at 1 fall outside SDRAM space: they only close the open row and are acknowledged.

Top module: `sdr_rowhit_ctrl`

## Requirements
- R1: Command encodings on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} are NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100 and PRECHARGE 0010. During and straight after reset the command is NOP, `ready` is 0, `sd_dqm` is 1 and `sd_dq_oe` is 0.
- R2: With `cfg_burst_en` at 0, each SDRAM access issues exactly one ACTIVE and one column command, then a PRECHARGE. If a row was left open beforehand, one more PRECHARGE comes before the ACTIVE.
- R3: With burst in effect and a row open, an SDRAM request whose row equals the open row and whose multiplex setting is unchanged issues only a READ or WRITE command, with no ACTIVE and no PRECHARGE. This goes on for any number of consecutive hits.
- R4: An SDRAM request that misses an open row issues PRECHARGE, then ACTIVE, then the column command. The row stays open afterwards when burst is in effect.
- R5: The column width is 3 + `cfg_mux` bits. The row is address bits [14:0] shifted right by the column width and is driven on `sd_addr` with ACTIVE. The column is driven on `sd_addr[9:0]` with READ/WRITE, with bit 10 low. PRECHARGE drives `sd_addr[10]` high. A change of `cfg_mux` counts as a row miss.
- R6: When `cfg_cas_lat` is 1, burst is treated as off whatever `cfg_burst_en` says, so every access is a full access.
- R7: `ready` rises for one cycle, exactly `cfg_cas_lat` cycles after the READ command, and `rdata` equals `sd_dq_in` in that cycle. A `cfg_cas_lat` of 0 acts as 3.
- R8: A write drives `wdata` on `sd_dq_out` with `sd_dq_oe` high and `sd_dqm` low during the WRITE command cycle. `ready` follows in the next cycle.
- R9: For an SDRAM read, `sd_dqm` is low in exactly one cycle: two cycles before the capture cycle. For an SDRAM write, it is low only in the WRITE cycle.
- R10: A request with address bit 15 set issues no ACTIVE and no column command. It issues a PRECHARGE only if a row is open, and then raises `ready` with `rdata` 0.
- R11: The open-row record is empty after reset and after every PRECHARGE. The next SDRAM access therefore issues ACTIVE with no preceding PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address; bit 15 = 1 selects outside SDRAM space |
| wdata | input | 16 | Write data |
| ready | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Read data, valid with `ready` |
| cfg_burst_en | input | 1 | Enables keeping the row open |
| cfg_mux | input | 3 | Column width select (3 + value bits) |
| cfg_cas_lat | input | 2 | CAS latency 1..3 |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_addr | output | 13 | Row / column address |
| sd_ba | output | 2 | Bank (address bits 14:13) |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Read data from memory |

## Verification
The hardest case to reach is a request that meets a row left open under different conditions. Examples are a row opened under another multiplex setting, a row opened before burst was disabled, and a row still open when the latency is switched to 1. In each case the open-row record must be treated as a miss rather than trusted. The bench reaches these by ending a burst sequence on purpose with the row still open and then changing one configuration input while the bus is idle. It then counts the ACTIVE and PRECHARGE commands the next request produces in a behavioural memory model. The DQM-ahead-of-data timing is checked at each latency, using the same model's count of masked cycles.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_RWAIT, ST_ACK
  } sdr_st_e;

  // row number: address with the column bits shifted away
  function automatic logic [31:0] row_of(input logic [31:0] a, input logic [2:0] mux,
                                         input int unsigned base);
    return a >> (base + 32'(mux));
  endfunction

  // column number: low (base + mux) address bits
  function automatic logic [31:0] col_of(input logic [31:0] a, input logic [2:0] mux,
                                         input int unsigned base);
    return a & ((32'd1 << (base + 32'(mux))) - 32'd1);
  endfunction

  function automatic logic burst_allowed(input logic en, input logic [1:0] cl);
    return en && (cl != 2'd1);
  endfunction

  function automatic logic [1:0] eff_cl(input logic [1:0] cl);
    return (cl == 2'd0) ? 2'd3 : cl;
  endfunction

endpackage

// File: rtl/sdr_open_row.sv
module sdr_open_row
  import sdr_pkg::*;
#(
  parameter int SD_W     = 15,
  parameter int COL_BASE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            open_set,
  input  logic            close,
  input  logic [SD_W-1:0] set_addr,
  input  logic [2:0]      set_mux,
  input  logic [SD_W-1:0] cmp_addr,
  input  logic [2:0]      cmp_mux,
  output logic            row_open,
  output logic            row_hit
);
  logic [SD_W-1:0] open_row_q;
  logic [2:0]      open_mux_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open   <= 1'b0;
      open_row_q <= '0;
      open_mux_q <= '0;
    end else if (close) begin
      row_open <= 1'b0;
    end else if (open_set) begin
      row_open   <= 1'b1;
      open_row_q <= SD_W'(row_of(32'(set_addr), set_mux, COL_BASE));
      open_mux_q <= set_mux;
    end
  end

  assign row_hit = row_open && (open_mux_q == cmp_mux) &&
                   (open_row_q == SD_W'(row_of(32'(cmp_addr), cmp_mux, COL_BASE)));
endmodule

// File: rtl/sdr_rd_timer.sv
module sdr_rd_timer
  import sdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] cl,
  output logic       capture,
  output logic       dqm_late
);
  logic [1:0] cnt_q;
  logic       busy_q;
  logic [1:0] lat;

  assign lat      = eff_cl(cl);
  assign capture  = busy_q && (cnt_q == lat);
  assign dqm_late = busy_q && (cnt_q == 2'd1) && (lat == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= 2'd1;
    end else if (capture) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/sdr_rowhit_ctrl.sv
module sdr_rowhit_ctrl
  import sdr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SA_W     = 13,
  parameter int BA_W     = 2,
  parameter int COL_BASE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  input  logic              cfg_burst_en,
  input  logic [2:0]        cfg_mux,
  input  logic [1:0]        cfg_cas_lat,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [SA_W-1:0]   sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int SD_W    = ADDR_W - 1;
  localparam int AP_BIT  = 10;

  sdr_st_e           st;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              req_we_q, req_sd_q, req_burst_q, closing_q;

  // named internal events, used by the checker
  logic ev_act, ev_pre, ev_col, ev_capture, ev_done;
  logic row_open, row_hit, dqm_late, burst_eff, in_sd;
  sdr_cmd_e cmd;

  assign in_sd     = ~addr[ADDR_W-1];
  assign burst_eff = burst_allowed(cfg_burst_en, cfg_cas_lat);
  assign ev_act    = (st == ST_ACT);
  assign ev_pre    = (st == ST_PRE);
  assign ev_col    = (st == ST_COL);
  assign ev_done   = (st == ST_ACK) || ((st == ST_RWAIT) && ev_capture);

  sdr_open_row #(.SD_W(SD_W), .COL_BASE(COL_BASE)) u_row (
    .clk(clk), .rst_n(rst_n),
    .open_set(ev_act), .close(ev_pre),
    .set_addr(req_addr_q[SD_W-1:0]), .set_mux(cfg_mux),
    .cmp_addr(addr[SD_W-1:0]), .cmp_mux(cfg_mux),
    .row_open(row_open), .row_hit(row_hit)
  );

  sdr_rd_timer u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start(ev_col && !req_we_q), .cl(cfg_cas_lat),
    .capture(ev_capture), .dqm_late(dqm_late)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      req_we_q    <= 1'b0;
      req_sd_q    <= 1'b0;
      req_burst_q <= 1'b0;
      closing_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req) begin
          req_addr_q  <= addr;
          req_wdata_q <= wdata;
          req_we_q    <= we;
          req_sd_q    <= in_sd;
          req_burst_q <= burst_eff;
          closing_q   <= 1'b0;
          if (in_sd && burst_eff && row_hit) st <= ST_COL;
          else if (row_open)                 st <= ST_PRE;
          else if (in_sd)                    st <= ST_ACT;
          else                               st <= ST_ACK;
        end
        ST_PRE: begin
          closing_q <= 1'b0;
          if (closing_q)     st <= ST_IDLE;
          else if (req_sd_q) st <= ST_ACT;
          else               st <= ST_ACK;
        end
        ST_ACT:  st <= ST_COL;
        ST_COL:  st <= req_we_q ? ST_ACK : ST_RWAIT;
        ST_ACK, ST_RWAIT: if (ev_done) begin
          if (req_sd_q && !req_burst_q) begin
            st        <= ST_PRE;
            closing_q <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd     = CMD_NOP;
    sd_addr = '0;
    sd_ba   = '0;
    if (ev_pre) begin
      cmd             = CMD_PRE;
      sd_addr[AP_BIT] = 1'b1;
    end else if (ev_act) begin
      cmd     = CMD_ACT;
      sd_addr = SA_W'(row_of(32'(req_addr_q[SD_W-1:0]), cfg_mux, COL_BASE));
      sd_ba   = req_addr_q[SD_W-1 -: BA_W];
    end else if (ev_col) begin
      cmd     = req_we_q ? CMD_WR : CMD_RD;
      sd_addr = SA_W'(col_of(32'(req_addr_q[SD_W-1:0]), cfg_mux, COL_BASE));
      sd_ba   = req_addr_q[SD_W-1 -: BA_W];
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  assign sd_dq_oe  = ev_col && req_we_q;
  assign sd_dq_out = sd_dq_oe ? req_wdata_q : '0;

  // read DQM leads its data by two cycles
  always_comb begin
    sd_dqm = 1'b1;
    if (sd_dq_oe)                                                     sd_dqm = 1'b0;
    if (ev_act && !req_we_q && eff_cl(cfg_cas_lat) == 2'd1)           sd_dqm = 1'b0;
    if (ev_col && !req_we_q && eff_cl(cfg_cas_lat) == 2'd2)           sd_dqm = 1'b0;
    if (dqm_late)                                                     sd_dqm = 1'b0;
  end

  assign ready = ev_done;
  assign rdata = ((st == ST_RWAIT) && ev_capture) ? sd_dq_in : '0;
endmodule

// File: rtl/sdr_rowhit_chk.sv
module sdr_rowhit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       sd_dqm,
  input logic [1:0] cfg_cas_lat,
  input logic       ev_act,
  input logic       ev_pre,
  input logic       ev_col,
  input logic       ev_capture,
  input logic       row_open
);
  // R3
  col_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_col |-> row_open);

  // R4
  act_needs_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |-> !row_open);

  // R11
  pre_clears_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |=> !row_open);

  // R6
  cl1_full_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_col && cfg_cas_lat == 2'd1) |-> $past(ev_act));

  // R9
  dqm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |-> ($past(sd_dqm, 2) == 1'b0));

  // R7
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

bind sdr_rowhit_ctrl sdr_rowhit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .sd_dqm(sd_dqm),
  .cfg_cas_lat(cfg_cas_lat), .ev_act(ev_act), .ev_pre(ev_pre),
  .ev_col(ev_col), .ev_capture(ev_capture), .row_open(row_open)
);

// File: tb/sdr_rowhit_ctrl_tb.sv
module sdr_rowhit_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic ready;
  logic [15:0] rdata;
  logic cfg_burst_en = 1'b1;
  logic [2:0] cfg_mux = 3'd2;
  logic [1:0] cfg_cas_lat = 2'd2;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [12:0] sd_addr;
  logic [1:0] sd_ba;
  logic [15:0] sd_dq_out, sd_dq_in;

  always #10 clk = ~clk;

  sdr_rowhit_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .cfg_burst_en(cfg_burst_en), .cfg_mux(cfg_mux),
    .cfg_cas_lat(cfg_cas_lat), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  // ---------------- behavioural memory model ----------------
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [12:0] m_row;
  logic [15:0] p1, p2, p3;
  int act_cnt = 0, pre_cnt = 0, dqm_cnt = 0, viol = 0, cyc = 0, rd_cyc = 0;
  logic [12:0] last_act_addr = '0, last_col_addr = '0;
  logic last_pre_a10 = 1'b0, wr_ok = 1'b0;
  logic [3:0] bus_cmd;
  logic [7:0] m_idx;

  assign bus_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign m_idx = 8'(({19'd0, m_row} << (3 + cfg_mux)) | {22'd0, sd_addr[9:0]});
  assign sd_dq_in = (cfg_cas_lat == 2'd1) ? p1 : (cfg_cas_lat == 2'd2) ? p2 : p3;

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    m_row = '0; p1 = '0; p2 = '0; p3 = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!sd_dqm) dqm_cnt <= dqm_cnt + 1;
    p2 <= p1; p3 <= p2; p1 <= 16'hxxxx;
    case (bus_cmd)
      4'b0011: begin act_cnt <= act_cnt + 1; m_row <= sd_addr; last_act_addr <= sd_addr; end
      4'b0010: begin pre_cnt <= pre_cnt + 1; last_pre_a10 <= sd_addr[10]; end
      4'b0100: begin
        mem[m_idx] <= sd_dq_out; last_col_addr <= sd_addr;
        wr_ok <= sd_dq_oe && !sd_dqm;
      end
      4'b0101: begin p1 <= mem[m_idx]; last_col_addr <= sd_addr; rd_cyc <= cyc; end
      4'b0111: ;
      default: if (rst_n) viol <= viol + 1;
    endcase
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d,
                        input int e_act, input int e_pre, input string tag);
    int a0, p0, q0, lat, n;
    logic [15:0] got;
    bit seen;
    a0 = act_cnt; p0 = pre_cnt; q0 = dqm_cnt; seen = 0; got = '0; lat = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    n = 0;
    while (!seen && n < 40) begin
      @(negedge clk);
      n++;
      if (ready) begin seen = 1; got = rdata; lat = cyc - rd_cyc; end
    end
    req = 1'b0;
    repeat (3) @(negedge clk);
    check(seen, {tag, " R7 ready seen"}, int'(seen), 1);
    check(act_cnt - a0 == e_act, {tag, " ACTIVE count"}, act_cnt - a0, e_act);
    check(pre_cnt - p0 == e_pre, {tag, " PRECHARGE count"}, pre_cnt - p0, e_pre);
    if (a[15]) begin
      check(got == 16'h0, {tag, " R10 rdata"}, int'(got), 0);
      check(dqm_cnt - q0 == 0, {tag, " R10 dqm cycles"}, dqm_cnt - q0, 0);
    end else begin
      check(dqm_cnt - q0 == 1, {tag, " R9 dqm cycles"}, dqm_cnt - q0, 1);
      if (w) begin
        exp_mem[a[7:0]] = d;
        check(wr_ok, {tag, " R8 write drive"}, int'(wr_ok), 1);
      end else begin
        check(got == exp_mem[a[7:0]], {tag, " R7 rdata"}, int'(got), int'(exp_mem[a[7:0]]));
        check(lat == int'(cfg_cas_lat), {tag, " R7 latency"}, lat, int'(cfg_cas_lat));
      end
    end
  endtask

  typedef struct packed {
    logic        w;
    logic [15:0] a;
    logic [15:0] d;
    logic [1:0]  act;
    logic [1:0]  pre;
  } vec_t;

  // burst on, CL2, mux 2 (5 column bits)
  localparam vec_t VEC [10] = '{
    '{1'b1, 16'h0041, 16'hA1A1, 2'd1, 2'd0},
    '{1'b1, 16'h0042, 16'hB2B2, 2'd0, 2'd0},
    '{1'b0, 16'h0041, 16'h0000, 2'd0, 2'd0},
    '{1'b0, 16'h0042, 16'h0000, 2'd0, 2'd0},
    '{1'b1, 16'h0065, 16'hC3C3, 2'd1, 2'd1},
    '{1'b0, 16'h0065, 16'h0000, 2'd0, 2'd0},
    '{1'b0, 16'h0043, 16'h0000, 2'd1, 2'd1},
    '{1'b1, 16'h2088, 16'hD4D4, 2'd1, 2'd1},
    '{1'b0, 16'h2088, 16'h0000, 2'd0, 2'd0},
    '{1'b0, 16'h0041, 16'h0000, 2'd1, 2'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bus_cmd == 4'b0111, "R1 command NOP in reset", int'(bus_cmd), 7);
    check(!ready && sd_dqm && !sd_dq_oe, "R1 ready/dqm/oe in reset",
          int'({ready, sd_dqm, sd_dq_oe}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_cmd == 4'b0111 && sd_dqm, "R1 idle after reset", int'(bus_cmd), 7);

    // R11 first access after reset; R3 hits; R4 misses
    for (int i = 0; i < 10; i++)
      access(VEC[i].w, VEC[i].a, VEC[i].d, int'(VEC[i].act), int'(VEC[i].pre), "R3 R4 R11 table");

    // R2 burst off: open row closed first, then full access
    cfg_burst_en = 1'b0;
    access(1'b1, 16'h0041, 16'hE5E5, 1, 2, "R2 burst off with open row");
    access(1'b0, 16'h0041, 16'h0000, 1, 1, "R2 burst off read");
    check(last_pre_a10, "R5 precharge A10", int'(last_pre_a10), 1);

    // R6 CL1 forces burst off
    cfg_burst_en = 1'b1; cfg_cas_lat = 2'd1;
    access(1'b1, 16'h0030, 16'h1234, 1, 1, "R6 CL1 write");
    access(1'b0, 16'h0030, 16'h0000, 1, 1, "R6 CL1 same-row read");

    // CL3 burst
    cfg_cas_lat = 2'd3;
    access(1'b0, 16'h0030, 16'h0000, 1, 0, "R7 CL3 read opens");
    access(1'b0, 16'h0031, 16'h0000, 0, 0, "R7 CL3 hit read");

    // R10 outside SDRAM space
    access(1'b0, 16'h8030, 16'h0000, 0, 1, "R10 closes open row");
    access(1'b0, 16'h8031, 16'h0000, 0, 0, "R10 no row open");
    access(1'b0, 16'h0030, 16'h0000, 1, 0, "R11 after precharge");

    // R5 multiplex boundary
    cfg_cas_lat = 2'd2; cfg_mux = 3'd0;
    access(1'b1, 16'h0030, 16'h5A5A, 1, 1, "R5 mux change misses");
    access(1'b1, 16'h0038, 16'h6B6B, 1, 1, "R5 narrow column splits row");
    check(last_act_addr == 13'd7, "R5 row on ACTIVE", int'(last_act_addr), 7);
    check(last_col_addr == 13'd0, "R5 column on WRITE", int'(last_col_addr), 0);
    cfg_mux = 3'd7;
    access(1'b0, 16'h0030, 16'h0000, 1, 1, "R5 wide mux miss");
    access(1'b0, 16'h03F0, 16'h0000, 0, 0, "R5 wide column hit");
    check(last_col_addr == 13'h3F0, "R5 wide column value", int'(last_col_addr), 'h3F0);
    check(viol == 0, "R1 illegal command codes", viol, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule